// File: doc/BRIEF.md
# Monochrome OLED Power-Up Command Sequencer

This block brings a page-organised monochrome OLED panel controller out of reset and configures it. When the chip reset is released, the block first drives the panel's reset line high for a fixed interval of about 4 µs. It then holds the line low for the same interval. After that it emits a fixed list of command bytes and their option bytes on a byte-wide valid/ready stream. The configuration fields arrive on static inputs, and the block packs each one into the bit positions the panel expects. The stream ends with the display-on command, and a done flag rises once that command has been accepted.

Two commands are optional and are left out of the stream when they are not enabled: the area-colour/low-power command and the grey-scale lookup table. The COM pin configuration byte inverts the polarity of the sequential-COM flag. After initialisation, a one-cycle request re-sends the contrast command with the current contrast input, which serves runtime brightness changes. A downstream serialiser for SPI or I2C consumes the stream.

Top module: `oled_init_seq`

## Requirements
- R1: After reset release, `panel_rst` is high for exactly RST_CYC = (CLK_FREQ_HZ/1e6)·RST_US clock cycles, then goes low and never rises again until the next reset; `tx_valid` is low while `panel_rst` is high.
- R2: After `panel_rst` falls, exactly RST_CYC cycles pass before `tx_valid` first rises.
- R3: The stream order is: 0x81, contrast; segment byte; COM-direction byte; 0xA8, height−1; 0xD3, COM offset; 0xD5, clock byte; [0xD8, mode byte]; 0xD9, precharge byte; 0xDA, COM-pins byte; 0xDB, VCOMH; 0x8D, pump byte; [0x91, LUT_LEN table bytes]; 0x20, addressing byte; 0xAF. `tx_is_data` is 0 (command) on every byte.
- R4: The segment byte is 0xA0 with `cfg_seg_remap` in bit 0. The COM-direction byte is 0xC0 with `cfg_com_rev` in bit 3. The clock byte holds `cfg_clk_div`−1 in bits 3:0 and `cfg_clk_frq` in bits 7:4. The precharge byte holds `cfg_pre1` in bits 3:0 and `cfg_pre2` in bits 7:4.
- R5: The COM-pins byte has bit 1 set, bit 4 equal to the inverse of `cfg_com_seq`, bit 5 equal to `cfg_com_lr`, and all other bits clear.
- R6: The 0xD8 pair is present only when `cfg_area_col` or `cfg_low_pwr` is set. Its mode byte is the OR of 0x1E (area colour) and 0x05 (low power).
- R7: The 0x91 command and the table bytes are present only when `cfg_lut_en` is set. Table byte k is `cfg_lut[8k+7:8k]`, and entries are sent from k=0 upward.
- R8: The pump byte is 0x10, with bit 2 also set when `cfg_pump_int` is set.
- R9: The addressing byte is 0x02 when `cfg_page_mode` is set or FORCE_PAGE_MODE is 1, and 0x00 otherwise.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R11: `init_done` rises in the cycle after the 0xAF byte is accepted and stays high until reset.
- R12: A one-cycle `upd_req` pulse while `init_done` is high emits 0x81 followed by `cfg_contrast`. A pulse before `init_done` is ignored and adds no bytes to the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_contrast | input | 8 | Contrast level |
| cfg_seg_remap | input | 1 | Segment remap flag |
| cfg_com_rev | input | 1 | COM scan direction reversed |
| cfg_height | input | 8 | Panel height in rows (1..64) |
| cfg_com_off | input | 8 | COM display offset |
| cfg_clk_div | input | 5 | Display clock divider (1..16) |
| cfg_clk_frq | input | 4 | Oscillator frequency code |
| cfg_area_col | input | 1 | Area-colour option |
| cfg_low_pwr | input | 1 | Low-power option |
| cfg_pre1 | input | 4 | Precharge phase 1 |
| cfg_pre2 | input | 4 | Precharge phase 2 |
| cfg_com_seq | input | 1 | Sequential COM pin layout |
| cfg_com_lr | input | 1 | COM left/right remap |
| cfg_vcomh | input | 8 | VCOMH level |
| cfg_pump_int | input | 1 | Internal charge pump needed |
| cfg_lut_en | input | 1 | Send the lookup table |
| cfg_lut | input | 8·LUT_LEN | Lookup table bytes, entry k in bits 8k+7:8k |
| cfg_page_mode | input | 1 | Page addressing mode |
| upd_req | input | 1 | Contrast re-send request |
| panel_rst | output | 1 | Panel reset, active high |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_is_data | output | 1 | 1 = display data, 0 = command |
| init_done | output | 1 | Initialisation complete |

## Verification
The reset pulse and the hold interval are each measured in whole cycles from reset release, and each is compared with RST_CYC. The bench counts falling-edge samples until the level changes, so an interval that is one cycle long or short is caught. Each stream byte is recorded at the falling edge that precedes the rising edge where `tx_valid` and `tx_ready` are both high, and it is compared with a list that the bench builds arithmetically for each of 16 swept configurations. `init_done` must first appear one cycle after the 0xAF byte is accepted. A contrast request is expected to put 0x81 on the stream one cycle after the request is sampled.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;
   typedef enum logic [2:0] {
      ST_RST_ON,
      ST_RST_WAIT,
      ST_RUN,
      ST_DONE,
      ST_UPD
   } seq_state_e;

   localparam logic [7:0] OP_CONTRAST = 8'h81;
   localparam logic [7:0] OP_SEG      = 8'hA0;
   localparam logic [7:0] OP_COMDIR   = 8'hC0;
   localparam logic [7:0] OP_MUX      = 8'hA8;
   localparam logic [7:0] OP_OFFSET   = 8'hD3;
   localparam logic [7:0] OP_CLOCK    = 8'hD5;
   localparam logic [7:0] OP_AREA     = 8'hD8;
   localparam logic [7:0] OP_PRECHG   = 8'hD9;
   localparam logic [7:0] OP_COMPINS  = 8'hDA;
   localparam logic [7:0] OP_VCOMH    = 8'hDB;
   localparam logic [7:0] OP_PUMP     = 8'h8D;
   localparam logic [7:0] OP_LUT      = 8'h91;
   localparam logic [7:0] OP_ADDRMODE = 8'h20;
   localparam logic [7:0] OP_DISP_ON  = 8'hAF;

   // steps before the table block
   localparam int FIXED_HEAD = 21;
   // steps after the table block: mode opcode, mode byte, display on
   localparam int FIXED_TAIL = 3;
endpackage

// File: rtl/oled_rst_timer.sv
module oled_rst_timer #(
   parameter int CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic expire
);
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   assign expire = (cnt == CNT_W'(CYCLES - 1));
endmodule

// File: rtl/oled_cmd_rom.sv
module oled_cmd_rom
   import oled_seq_pkg::*;
#(
   parameter int LUT_LEN         = 4,
   parameter bit FORCE_PAGE_MODE = 1'b0,
   parameter int IDX_W           = 5
) (
   input  logic [IDX_W-1:0]     idx,
   input  logic [7:0]           cfg_contrast,
   input  logic                 cfg_seg_remap,
   input  logic                 cfg_com_rev,
   input  logic [7:0]           cfg_height,
   input  logic [7:0]           cfg_com_off,
   input  logic [4:0]           cfg_clk_div,
   input  logic [3:0]           cfg_clk_frq,
   input  logic                 cfg_area_col,
   input  logic                 cfg_low_pwr,
   input  logic [3:0]           cfg_pre1,
   input  logic [3:0]           cfg_pre2,
   input  logic                 cfg_com_seq,
   input  logic                 cfg_com_lr,
   input  logic [7:0]           cfg_vcomh,
   input  logic                 cfg_pump_int,
   input  logic                 cfg_lut_en,
   input  logic [LUT_LEN*8-1:0] cfg_lut,
   input  logic                 cfg_page_mode,
   output logic [7:0]           byte_o,
   output logic                 skip_o
);
   localparam int LUT_BASE = FIXED_HEAD;
   localparam int ADDR_OP  = FIXED_HEAD + LUT_LEN;
   localparam int LSEL_W   = (LUT_LEN > 1) ? $clog2(LUT_LEN) : 1;

   logic [7:0]        lut_b [LUT_LEN];
   logic [7:0]        mode_byte;
   logic [4:0]        div_m1;
   logic [7:0]        area_byte;
   logic              area_skip;
   logic [LSEL_W-1:0] lut_sel;

   for (genvar g = 0; g < LUT_LEN; g++) begin : g_lut
      assign lut_b[g] = cfg_lut[g*8 +: 8];
   end

   if (FORCE_PAGE_MODE) begin : g_page_only
      assign mode_byte = 8'h02;
   end else begin : g_mode_sel
      assign mode_byte = cfg_page_mode ? 8'h02 : 8'h00;
   end

   assign div_m1    = cfg_clk_div - 5'd1;
   assign area_skip = !(cfg_area_col || cfg_low_pwr);
   assign area_byte = (cfg_area_col ? 8'h1E : 8'h00) | (cfg_low_pwr ? 8'h05 : 8'h00);
   assign lut_sel   = LSEL_W'(idx - IDX_W'(LUT_BASE));

   always_comb begin
      byte_o = 8'h00;
      skip_o = 1'b0;
      case (idx)
         IDX_W'(0):  byte_o = OP_CONTRAST;
         IDX_W'(1):  byte_o = cfg_contrast;
         IDX_W'(2):  byte_o = OP_SEG | {7'd0, cfg_seg_remap};
         IDX_W'(3):  byte_o = OP_COMDIR | {4'd0, cfg_com_rev, 3'd0};
         IDX_W'(4):  byte_o = OP_MUX;
         IDX_W'(5):  byte_o = cfg_height - 8'd1;
         IDX_W'(6):  byte_o = OP_OFFSET;
         IDX_W'(7):  byte_o = cfg_com_off;
         IDX_W'(8):  byte_o = OP_CLOCK;
         IDX_W'(9):  byte_o = {cfg_clk_frq, div_m1[3:0]};
         IDX_W'(10): begin byte_o = OP_AREA;  skip_o = area_skip; end
         IDX_W'(11): begin byte_o = area_byte; skip_o = area_skip; end
         IDX_W'(12): byte_o = OP_PRECHG;
         IDX_W'(13): byte_o = {cfg_pre2, cfg_pre1};
         IDX_W'(14): byte_o = OP_COMPINS;
         IDX_W'(15): byte_o = {2'b00, cfg_com_lr, ~cfg_com_seq, 4'b0010};
         IDX_W'(16): byte_o = OP_VCOMH;
         IDX_W'(17): byte_o = cfg_vcomh;
         IDX_W'(18): byte_o = OP_PUMP;
         IDX_W'(19): byte_o = 8'h10 | {5'd0, cfg_pump_int, 2'b00};
         IDX_W'(20): begin byte_o = OP_LUT; skip_o = !cfg_lut_en; end
         IDX_W'(ADDR_OP):     byte_o = OP_ADDRMODE;
         IDX_W'(ADDR_OP + 1): byte_o = mode_byte;
         IDX_W'(ADDR_OP + 2): byte_o = OP_DISP_ON;
         default: begin
            if (idx >= IDX_W'(LUT_BASE) && idx < IDX_W'(ADDR_OP)) begin
               byte_o = lut_b[lut_sel];
               skip_o = !cfg_lut_en;
            end
         end
      endcase
   end
endmodule

// File: rtl/oled_seq_ctrl.sv
module oled_seq_ctrl
   import oled_seq_pkg::*;
#(
   parameter int IDX_W    = 5,
   parameter int LAST_IDX = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_expire,
   input  logic             rom_skip,
   input  logic             tx_ready,
   input  logic             upd_req,
   output seq_state_e       state,
   output logic [IDX_W-1:0] idx,
   output logic             tx_valid,
   output logic             tmr_clear
);
   always_comb begin
      tx_valid  = ((state == ST_RUN) && !rom_skip) || (state == ST_UPD);
      tmr_clear = tmr_expire || !((state == ST_RST_ON) || (state == ST_RST_WAIT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RST_ON;
         idx   <= '0;
      end else begin
         case (state)
            ST_RST_ON: if (tmr_expire) state <= ST_RST_WAIT;
            ST_RST_WAIT: begin
               if (tmr_expire) begin
                  state <= ST_RUN;
                  idx   <= '0;
               end
            end
            ST_RUN: begin
               if (rom_skip || tx_ready) begin
                  if (idx == IDX_W'(LAST_IDX)) begin
                     state <= ST_DONE;
                     idx   <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_DONE: begin
               if (upd_req) begin
                  state <= ST_UPD;
                  idx   <= '0;
               end
            end
            ST_UPD: begin
               if (tx_ready) begin
                  if (idx == IDX_W'(1)) begin
                     state <= ST_DONE;
                     idx   <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: state <= ST_RST_ON;
         endcase
      end
   end
endmodule

// File: rtl/oled_init_seq.sv
module oled_init_seq
   import oled_seq_pkg::*;
#(
   parameter int CLK_FREQ_HZ     = 50_000_000,
   parameter int RST_US          = 4,
   parameter int LUT_LEN         = 4,
   parameter bit FORCE_PAGE_MODE = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           cfg_contrast,
   input  logic                 cfg_seg_remap,
   input  logic                 cfg_com_rev,
   input  logic [7:0]           cfg_height,
   input  logic [7:0]           cfg_com_off,
   input  logic [4:0]           cfg_clk_div,
   input  logic [3:0]           cfg_clk_frq,
   input  logic                 cfg_area_col,
   input  logic                 cfg_low_pwr,
   input  logic [3:0]           cfg_pre1,
   input  logic [3:0]           cfg_pre2,
   input  logic                 cfg_com_seq,
   input  logic                 cfg_com_lr,
   input  logic [7:0]           cfg_vcomh,
   input  logic                 cfg_pump_int,
   input  logic                 cfg_lut_en,
   input  logic [LUT_LEN*8-1:0] cfg_lut,
   input  logic                 cfg_page_mode,
   input  logic                 upd_req,
   output logic                 panel_rst,
   output logic                 tx_valid,
   input  logic                 tx_ready,
   output logic [7:0]           tx_data,
   output logic                 tx_is_data,
   output logic                 init_done
);
   localparam int RST_CYC   = (CLK_FREQ_HZ / 1_000_000) * RST_US;
   localparam int N_STEPS   = FIXED_HEAD + LUT_LEN + FIXED_TAIL;
   localparam int LAST_IDX  = N_STEPS - 1;
   localparam int IDX_W     = $clog2(N_STEPS + 1);

   if (RST_CYC < 1) begin : g_bad_rst
      $error("reset interval must be at least one clock cycle");
   end
   if (LUT_LEN < 1 || LUT_LEN > 32) begin : g_bad_lut
      $error("LUT_LEN must lie in 1..32");
   end

   seq_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             tmr_clear;
   logic             tmr_expire;
   logic             rom_skip;

   oled_rst_timer #(.CYCLES(RST_CYC)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (tmr_clear),
      .expire (tmr_expire)
   );

   oled_cmd_rom #(
      .LUT_LEN         (LUT_LEN),
      .FORCE_PAGE_MODE (FORCE_PAGE_MODE),
      .IDX_W           (IDX_W)
   ) u_rom (
      .idx           (idx),
      .cfg_contrast  (cfg_contrast),
      .cfg_seg_remap (cfg_seg_remap),
      .cfg_com_rev   (cfg_com_rev),
      .cfg_height    (cfg_height),
      .cfg_com_off   (cfg_com_off),
      .cfg_clk_div   (cfg_clk_div),
      .cfg_clk_frq   (cfg_clk_frq),
      .cfg_area_col  (cfg_area_col),
      .cfg_low_pwr   (cfg_low_pwr),
      .cfg_pre1      (cfg_pre1),
      .cfg_pre2      (cfg_pre2),
      .cfg_com_seq   (cfg_com_seq),
      .cfg_com_lr    (cfg_com_lr),
      .cfg_vcomh     (cfg_vcomh),
      .cfg_pump_int  (cfg_pump_int),
      .cfg_lut_en    (cfg_lut_en),
      .cfg_lut       (cfg_lut),
      .cfg_page_mode (cfg_page_mode),
      .byte_o        (tx_data),
      .skip_o        (rom_skip)
   );

   oled_seq_ctrl #(.IDX_W(IDX_W), .LAST_IDX(LAST_IDX)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .tmr_expire (tmr_expire),
      .rom_skip   (rom_skip),
      .tx_ready   (tx_ready),
      .upd_req    (upd_req),
      .state      (state),
      .idx        (idx),
      .tx_valid   (tx_valid),
      .tmr_clear  (tmr_clear)
   );

   assign panel_rst  = (state == ST_RST_ON);
   assign init_done  = (state == ST_DONE) || (state == ST_UPD);
   assign tx_is_data = 1'b0;
endmodule

// File: rtl/oled_init_seq_chk.sv
module oled_init_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       panel_rst,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       init_done
);
   a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      panel_rst |-> !tx_valid);

   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !panel_rst |=> !panel_rst);

   a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   a_r11_done_after_on: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> $past(tx_valid && tx_ready && (tx_data == 8'hAF)));

   a_r11_no_reset_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> !panel_rst);
endmodule

bind oled_init_seq oled_init_seq_chk u_chk (.*);

// File: tb/oled_init_seq_tb.sv
module oled_init_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LUT_LEN    = 4;
   localparam int RST_CYC    = 8;   // 2 MHz * 4 us

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [7:0]           cfg_contrast = 8'd127;
   logic                 cfg_seg_remap = 1'b0;
   logic                 cfg_com_rev = 1'b0;
   logic [7:0]           cfg_height = 8'd64;
   logic [7:0]           cfg_com_off = 8'd0;
   logic [4:0]           cfg_clk_div = 5'd1;
   logic [3:0]           cfg_clk_frq = 4'd8;
   logic                 cfg_area_col = 1'b0;
   logic                 cfg_low_pwr = 1'b0;
   logic [3:0]           cfg_pre1 = 4'd2;
   logic [3:0]           cfg_pre2 = 4'd2;
   logic                 cfg_com_seq = 1'b0;
   logic                 cfg_com_lr = 1'b0;
   logic [7:0]           cfg_vcomh = 8'h20;
   logic                 cfg_pump_int = 1'b0;
   logic                 cfg_lut_en = 1'b0;
   logic [LUT_LEN*8-1:0] cfg_lut = '0;
   logic                 cfg_page_mode = 1'b0;
   logic                 upd_req = 1'b0;
   logic                 tx_ready = 1'b0;
   logic                 panel_rst, tx_valid, tx_is_data, init_done;
   logic [7:0]           tx_data;

   int total = 0;
   int bad   = 0;
   int exp_b [64];
   int exp_n;
   int got_b [64];
   int got_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   oled_init_seq #(
      .CLK_FREQ_HZ(2_000_000), .RST_US(4), .LUT_LEN(LUT_LEN), .FORCE_PAGE_MODE(1'b0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_contrast(cfg_contrast), .cfg_seg_remap(cfg_seg_remap),
      .cfg_com_rev(cfg_com_rev), .cfg_height(cfg_height), .cfg_com_off(cfg_com_off),
      .cfg_clk_div(cfg_clk_div), .cfg_clk_frq(cfg_clk_frq), .cfg_area_col(cfg_area_col),
      .cfg_low_pwr(cfg_low_pwr), .cfg_pre1(cfg_pre1), .cfg_pre2(cfg_pre2),
      .cfg_com_seq(cfg_com_seq), .cfg_com_lr(cfg_com_lr), .cfg_vcomh(cfg_vcomh),
      .cfg_pump_int(cfg_pump_int), .cfg_lut_en(cfg_lut_en), .cfg_lut(cfg_lut),
      .cfg_page_mode(cfg_page_mode), .upd_req(upd_req), .panel_rst(panel_rst),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_is_data(tx_is_data), .init_done(init_done)
   );

   task automatic check(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic push(input int v);
      exp_b[exp_n] = v & 8'hFF;
      exp_n++;
   endtask

   task automatic build_expected();
      exp_n = 0;
      push(8'h81); push(cfg_contrast);
      push(8'hA0 + cfg_seg_remap);
      push(8'hC0 + (cfg_com_rev * 8));
      push(8'hA8); push(cfg_height - 1);
      push(8'hD3); push(cfg_com_off);
      push(8'hD5); push(cfg_clk_frq * 16 + (cfg_clk_div - 1));
      if (cfg_area_col || cfg_low_pwr) begin
         push(8'hD8); push((cfg_area_col ? 8'h1E : 0) | (cfg_low_pwr ? 8'h05 : 0));
      end
      push(8'hD9); push(cfg_pre2 * 16 + cfg_pre1);
      push(8'hDA); push(2 + (cfg_com_seq ? 0 : 16) + (cfg_com_lr ? 32 : 0));
      push(8'hDB); push(cfg_vcomh);
      push(8'h8D); push(8'h10 + (cfg_pump_int ? 4 : 0));
      if (cfg_lut_en) begin
         push(8'h91);
         for (int k = 0; k < LUT_LEN; k++) push(cfg_lut[k*8 +: 8]);
      end
      push(8'h20); push(cfg_page_mode ? 2 : 0);
      push(8'hAF);
   endtask

   function automatic logic ready_pat(input int mode, input int cyc);
      if (mode == 0) return 1'b1;
      if (mode == 1) return cyc[0];
      return (cyc % 3) == 2;
   endfunction

   task automatic run_cfg(input int n);
      int cnt;
      int cyc;
      int acc_cyc;
      int done_cyc;
      logic prev_stall;
      logic [7:0] prev_data;
      @(negedge clk);
      rst_n = 1'b0;
      tx_ready = 1'b0;
      upd_req = 1'b0;
      cfg_area_col  = n[0];
      cfg_low_pwr   = n[1];
      cfg_lut_en    = n[2];
      cfg_page_mode = n[3];
      cfg_seg_remap = n[0] ^ n[3];
      cfg_com_rev   = n[1] ^ n[0];
      cfg_com_seq   = n[1] ^ n[2];
      cfg_com_lr    = n[2] ^ n[0];
      cfg_pump_int  = n[3] ^ n[0];
      cfg_contrast  = 8'(n * 17);
      cfg_height    = 8'(16 + n * 3);
      cfg_com_off   = 8'(n * 5);
      cfg_clk_div   = 5'(n + 1);
      cfg_clk_frq   = 4'(15 - n);
      cfg_pre1      = 4'(n);
      cfg_pre2      = 4'(~n);
      cfg_vcomh     = 8'(8'h20 + n);
      for (int k = 0; k < LUT_LEN; k++) cfg_lut[k*8 +: 8] = 8'(31 + n + k * 8);
      build_expected();
      repeat (3) @(negedge clk);
      check("R1 reset state panel_rst", panel_rst, 1);
      check("R1 reset state tx_valid", tx_valid, 0);
      check("R11 reset state init_done", init_done, 0);
      rst_n = 1'b1;
      cnt = 0;
      while (panel_rst && cnt < 1000) begin
         @(negedge clk);
         cnt++;
         if (panel_rst && tx_valid) check("R1 valid during reset pulse", 1, 0);
      end
      check("R1 reset pulse length", cnt, RST_CYC);
      cnt = 0;
      while (!tx_valid && cnt < 1000) begin
         @(negedge clk);
         cnt++;
         if (panel_rst) check("R1 reset re-asserted", 1, 0);
      end
      check("R2 hold interval", cnt, RST_CYC);
      // stream collection
      got_n = 0;
      cyc = 0;
      acc_cyc = -10;
      done_cyc = -1;
      prev_stall = 1'b0;
      prev_data = '0;
      tx_ready = ready_pat(n % 3, cyc);
      while (!init_done && cyc < 2000) begin
         if (prev_stall) begin
            check("R10 valid held on stall", tx_valid, 1);
            check("R10 data held on stall", tx_data, prev_data);
         end
         if (tx_valid) check("R3 command flag", tx_is_data, 0);
         if (tx_valid && tx_ready) begin
            if (got_n < 64) got_b[got_n] = tx_data;
            got_n++;
            acc_cyc = cyc;
         end
         prev_stall = tx_valid && !tx_ready;
         prev_data  = tx_data;
         @(negedge clk);
         cyc++;
         // R12: early requests during initialisation must be ignored
         upd_req = (n[0] && cyc >= 5 && cyc < 9);
         tx_ready = ready_pat(n % 3, cyc);
      end
      upd_req = 1'b0;
      done_cyc = cyc;
      check("R11 done one cycle after display-on", done_cyc - acc_cyc, 1);
      check("R3 R6 R7 R12 stream length", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
         string tag;
         if (i == 15 || i == 13) tag = "R5 R4 field byte";
         else if (exp_b[i] == 8'hD8) tag = "R6 area opcode";
         else if (i == got_n - 2) tag = "R9 addressing byte";
         else tag = "R3 R4 R7 R8 stream byte";
         check(tag, got_b[i], exp_b[i]);
      end
      // contrast update after done
      cfg_contrast = 8'(8'hF0 - n);
      tx_ready = 1'b1;
      upd_req = 1'b1;
      @(negedge clk);
      upd_req = 1'b0;
      check("R12 update opcode valid", tx_valid, 1);
      check("R12 update opcode", tx_data, 8'h81);
      @(negedge clk);
      check("R12 update value valid", tx_valid, 1);
      check("R12 update value", tx_data, 8'hF0 - n);
      @(negedge clk);
      check("R12 update ends", tx_valid, 0);
      check("R11 done stays high", init_done, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int n = 0; n < 16; n++) run_cfg(n);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule